// File: doc/BRIEF.md
# Phase-Difference Frequency Discriminator

This block turns a stream of phase samples into instantaneous frequency. Each accepted phase sample is first scaled by a selectable power of two, and the scaled value is compared with the scaled value from a programmable number of samples earlier. The difference wraps in two's complement, so a phase ramp that passes through the full-turn boundary gives the correct frequency. The 18-bit difference is rounded to a 16-bit frequency word.

The power-of-two scaling strips phase modulation before differencing. With a factor of 2 a BPSK carrier loses its half-turn jumps, with 4 a QPSK carrier loses its quarter-turn jumps, and with 8 an 8PSK carrier loses its eighth-turn jumps. Each doubling of the factor halves the frequency range that is free of aliasing. A single configuration word holds the delay, the scaling exponent and an enable bit. The upstream polar conversion and any downstream filtering sit outside this block.

Top module: `phase_freq_disc`

## Requirements
- R1: While reset is asserted and after it is released, `out_valid` is 0 and `out_freq` is 0 until the first frequency word is produced.
- R2: `cfg_word[2:0]` holds the delay minus one (0 means 1 sample, 7 means 8 samples). Each output is the scaled newest accepted sample minus the scaled sample accepted D samples before it.
- R3: The subtraction is taken modulo 2^18. A ramp that crosses the 0x3FFFF/0x00000 boundary gives the same frequency as a ramp that does not cross it.
- R4: `cfg_word[16:15]` is an exponent k (00 gives x1, 01 gives x2, 10 gives x4, 11 gives x8). Every phase is shifted left by k bits and kept to 18 bits before differencing.
- R5: The 18-bit difference plus 2, taken modulo 2^18, supplies bits 17:2, and these become `out_freq`.
- R6: `out_valid` is a one-cycle pulse in the cycle after the clock edge that accepted the sample. `out_freq` changes only together with such a pulse and holds its value otherwise.
- R7: After reset, and after any edge at which the delay field differs from its value at the previous edge, the first D accepted samples produce no output.
- R8: While `cfg_word[14]` is 0, no sample is accepted and `out_valid` stays 0. The delay history is flushed, so after re-enabling the first D samples again produce no output.
- R9: A cycle with `in_valid` low neither advances the delay history nor produces output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_word | input | 17 | Configuration: [2:0] delay minus one, [14] enable, [16:15] scaling exponent; other bits unused |
| in_valid | input | 1 | Qualifies `in_phase` |
| in_phase | input | 18 | Phase sample, full turn equals 2^18 |
| out_valid | output | 1 | Frequency word valid pulse |
| out_freq | output | 16 | Rounded frequency word |

## Verification
A corrupted history entry shows up as a wrong frequency word. It appears at the first output that subtracts that entry, which comes D accepted samples after the entry was written. The bench therefore runs constant ramps, in which every correct output is identical and a single bad word stands out. A wrong fill count shows at the ports within one sample: either a pulse arrives that should have been suppressed after a restart, or a pulse that should follow the D-th sample is missing. Ramps that cross the wrap point, and PSK-style phase jumps under each scaling factor, expose wrong wrap or shift arithmetic in the very next output word.

// File: rtl/pd_pkg.sv
package pd_pkg;
  parameter int PHASE_W   = 18;
  parameter int FREQ_W    = 16;
  parameter int MAX_DELAY = 8;
  parameter int CFG_W     = 17;

  localparam int DSEL_W   = $clog2(MAX_DELAY);
  localparam int MUL_W    = 2;
  localparam int CNT_W    = $clog2(MAX_DELAY + 1);

  // configuration field positions
  localparam int CFG_DSEL_LO = 0;
  localparam int CFG_EN_BIT  = 14;
  localparam int CFG_MUL_LO  = 15;
endpackage

// File: rtl/pd_scaler.sv
module pd_scaler #(
  parameter int W     = 18,
  parameter int MUL_W = 2
) (
  input  logic [W-1:0]     phase_in,
  input  logic [MUL_W-1:0] exp_sel,
  output logic [W-1:0]     phase_out
);
  // left shift drops the upper bits: wrap modulo a full turn
  always_comb begin
    phase_out = phase_in << exp_sel;
  end
endmodule

// File: rtl/pd_history.sv
module pd_history #(
  parameter int W     = 18,
  parameter int DEPTH = 8,
  parameter int SEL_W = 3,
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             shift_en,
  input  logic             flush,
  input  logic             restart,
  input  logic [SEL_W-1:0] sel,
  input  logic [W-1:0]     din,
  output logic [W-1:0]     tap,
  output logic             filled
);
  logic [W-1:0]     stage_q [DEPTH];
  logic [W-1:0]     stage_d [DEPTH];
  logic [CNT_W-1:0] cnt_q, cnt_d;

  // stage 0 holds the latest accepted sample
  always_comb begin
    stage_d[0] = stage_q[0];
    if (flush)         stage_d[0] = '0;
    else if (shift_en) stage_d[0] = din;
  end

  for (genvar g = 1; g < DEPTH; g++) begin : g_stage
    always_comb begin
      stage_d[g] = stage_q[g];
      if (flush)         stage_d[g] = '0;
      else if (shift_en) stage_d[g] = stage_q[g-1];
    end
  end

  for (genvar g = 0; g < DEPTH; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '0;
      else        stage_q[g] <= stage_d[g];
    end
  end

  always_comb begin
    cnt_d = cnt_q;
    if (flush) begin
      cnt_d = '0;
    end else if (shift_en) begin
      if (restart)                         cnt_d = CNT_W'(1);
      else if (cnt_q < CNT_W'(DEPTH))      cnt_d = cnt_q + CNT_W'(1);
    end else if (restart) begin
      cnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign tap    = stage_q[sel];
  assign filled = cnt_q > CNT_W'(sel);
endmodule

// File: rtl/pd_diff_round.sv
module pd_diff_round #(
  parameter int W_IN  = 18,
  parameter int W_OUT = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             fire,
  input  logic [W_IN-1:0]  newest,
  input  logic [W_IN-1:0]  oldest,
  output logic             valid_q,
  output logic [W_OUT-1:0] freq_q
);
  localparam int         DROP = W_IN - W_OUT;
  localparam logic [W_IN-1:0] HALF = W_IN'(1) << (DROP - 1);

  logic [W_IN-1:0]  diff, biased;
  logic [W_OUT-1:0] freq_d;

  always_comb begin
    diff   = newest - oldest;   // modulo 2^W_IN
    biased = diff + HALF;
    freq_d = biased[W_IN-1:DROP];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      freq_q  <= '0;
    end else begin
      valid_q <= fire;
      if (fire) freq_q <= freq_d;
    end
  end
endmodule

// File: rtl/phase_freq_disc.sv
module phase_freq_disc
  import pd_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic [CFG_W-1:0]    cfg_word,
  input  logic                in_valid,
  input  logic [PHASE_W-1:0]  in_phase,
  output logic                out_valid,
  output logic [FREQ_W-1:0]   out_freq
);
  logic              enable;
  logic [DSEL_W-1:0] dsel, dsel_q;
  logic [MUL_W-1:0]  mul_exp;
  logic              accept, restart, fire, filled;
  logic [PHASE_W-1:0] scaled, tap;
  logic              unused_cfg_bits;

  assign enable  = cfg_word[CFG_EN_BIT];
  assign dsel    = cfg_word[CFG_DSEL_LO +: DSEL_W];
  assign mul_exp = cfg_word[CFG_MUL_LO +: MUL_W];
  assign unused_cfg_bits = ^cfg_word[CFG_EN_BIT-1:CFG_DSEL_LO+DSEL_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) dsel_q <= '0;
    else        dsel_q <= dsel;
  end

  always_comb begin
    accept  = in_valid & enable;
    restart = (dsel != dsel_q);
    fire    = accept & ~restart & filled;
  end

  pd_scaler #(.W(PHASE_W), .MUL_W(MUL_W)) u_scale (
    .phase_in (in_phase),
    .exp_sel  (mul_exp),
    .phase_out(scaled)
  );

  pd_history #(.W(PHASE_W), .DEPTH(MAX_DELAY), .SEL_W(DSEL_W), .CNT_W(CNT_W)) u_hist (
    .clk     (clk),
    .rst_n   (rst_n),
    .shift_en(accept),
    .flush   (~enable),
    .restart (restart),
    .sel     (dsel),
    .din     (scaled),
    .tap     (tap),
    .filled  (filled)
  );

  pd_diff_round #(.W_IN(PHASE_W), .W_OUT(FREQ_W)) u_diff (
    .clk    (clk),
    .rst_n  (rst_n),
    .fire   (fire),
    .newest (scaled),
    .oldest (tap),
    .valid_q(out_valid),
    .freq_q (out_freq)
  );
endmodule

// File: rtl/pd_checker.sv
module pd_checker
  import pd_pkg::*;
(
  input logic               clk,
  input logic               rst_n,
  input logic [CFG_W-1:0]   cfg_word,
  input logic               in_valid,
  input logic               out_valid,
  input logic [FREQ_W-1:0]  out_freq
);
  logic [1:0] age;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           age <= 2'd0;
    else if (age != 2'd2) age <= age + 2'd1;
  end

  // R6: a pulse only follows an edge that saw a valid sample
  a_r6_pulse_needs_input: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && age != 2'd0) |-> $past(in_valid));

  // R6: frequency word moves only with a pulse
  a_r6_hold_freq: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_valid && age != 2'd0) |-> $stable(out_freq));

  // R8: disabled block stays silent
  a_r8_disabled_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (age != 2'd0 && !$past(cfg_word[CFG_EN_BIT])) |-> !out_valid);

  // R7: a delay change suppresses the output of that edge
  a_r7_restart_on_delay_change: assert property (@(posedge clk) disable iff (!rst_n)
    (age == 2'd2 && $past(cfg_word[DSEL_W-1:0]) != $past(cfg_word[DSEL_W-1:0], 2)) |-> !out_valid);
endmodule

bind phase_freq_disc pd_checker u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .cfg_word (cfg_word),
  .in_valid (in_valid),
  .out_valid(out_valid),
  .out_freq (out_freq)
);

// File: tb/sim_phase_freq_disc.sv
`timescale 1ns/1ps
module sim_phase_freq_disc;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [16:0] cfg_word;
  logic        in_valid;
  logic [17:0] in_phase;
  logic        out_valid;
  logic [15:0] out_freq;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  // reference state
  logic [17:0] ref_line [8];
  int          ref_cnt;
  logic [2:0]  ref_dlast;
  logic [15:0] ref_freq;

  always #2.5 clk = ~clk;

  phase_freq_disc u0 (
    .clk(clk), .rst_n(rst_n), .cfg_word(cfg_word), .in_valid(in_valid),
    .in_phase(in_phase), .out_valid(out_valid), .out_freq(out_freq)
  );

  function automatic logic [16:0] mk_cfg(input bit en, input logic [1:0] k, input logic [2:0] dm1);
    logic [16:0] c;
    c = '0;
    c[2:0]   = dm1;
    c[14]    = en;
    c[16:15] = k;
    return c;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic ref_reset();
    for (int i = 0; i < 8; i++) ref_line[i] = '0;
    ref_cnt = 0; ref_dlast = '0; ref_freq = '0;
  endtask

  // one clock: drive at negedge, check after the following posedge
  task automatic step(input string req, input bit v, input logic [17:0] ph);
    bit en; logic [2:0] d; logic [1:0] k; bit clr, exp_v;
    logic [17:0] sc, df, bi;
    en = cfg_word[14]; d = cfg_word[2:0]; k = cfg_word[16:15];
    in_valid = v; in_phase = ph;
    sc = ph << k;
    clr = !en || (d != ref_dlast);
    exp_v = v && en && !clr && (ref_cnt >= int'(d) + 1);
    df = sc - ref_line[d];
    bi = df + 18'd2;
    if (exp_v) ref_freq = bi[17:2];
    if (!en) begin
      for (int i = 0; i < 8; i++) ref_line[i] = '0;
      ref_cnt = 0;
    end else if (v) begin
      for (int i = 7; i > 0; i--) ref_line[i] = ref_line[i-1];
      ref_line[0] = sc;
      ref_cnt = (d != ref_dlast) ? 1 : ((ref_cnt < 8) ? ref_cnt + 1 : 8);
    end else if (d != ref_dlast) begin
      ref_cnt = 0;
    end
    ref_dlast = d;
    @(posedge clk); @(negedge clk);
    in_valid = 1'b0;
    chk({req, " R6 valid"}, 32'(out_valid), 32'(exp_v));
    chk({req, " freq"}, 32'(out_freq), 32'(ref_freq));
  endtask

  task automatic do_reset();
    rst_n = 1'b0; in_valid = 1'b0; in_phase = '0; cfg_word = mk_cfg(1, 0, 0);
    ref_reset();
    repeat (3) @(negedge clk);
    chk("R1 reset valid", 32'(out_valid), 0);
    chk("R1 reset freq", 32'(out_freq), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", 32'(out_valid), 0);
  endtask

  task automatic t_round();
    cfg_word = mk_cfg(1, 0, 0);
    step("R7 first sample", 1, 18'd0);
    chk("R7 no output on first sample", 32'(out_valid), 0);
    step("R5 diff 1", 1, 18'd1);
    chk("R5 diff 1 rounds to 0", 32'(out_freq), 0);
    step("R5 diff 2", 1, 18'd3);
    chk("R5 diff 2 rounds to 1", 32'(out_freq), 1);
    step("R5 diff 6", 1, 18'd9);
    chk("R5 diff 6 rounds to 2", 32'(out_freq), 2);
  endtask

  task automatic t_wrap();
    cfg_word = mk_cfg(1, 0, 0);
    step("R3 pre", 1, 18'h3FFF0);
    step("R3 up across wrap", 1, 18'h00010);
    chk("R3 +32 across wrap", 32'(out_freq), 16'h0008);
    step("R3 down across wrap", 1, 18'h3FFF0);
    chk("R3 -32 across wrap", 32'(out_freq), 16'hFFF8);
    for (int i = 0; i < 10; i++) step("R3 ramp", 1, 18'(32'h3FF00 + 32'(i) * 32'h40));
  endtask

  task automatic t_delay8();
    cfg_word = mk_cfg(1, 0, 7);
    for (int i = 0; i < 8; i++) begin
      step("R7 fill D=8", 1, 18'(i * 100));
      chk("R7 silent while filling", 32'(out_valid), 0);
    end
    step("R2 D=8 first out", 1, 18'd800);
    chk("R2 D=8 slope", 32'(out_freq), 32'd200);
    for (int i = 9; i < 14; i++) step("R2 D=8 ramp", 1, 18'(i * 100));
  endtask

  task automatic t_psk();
    logic [17:0] base;
    for (int k = 1; k < 4; k++) begin
      cfg_word = mk_cfg(1, 2'(k), 0);
      for (int i = 0; i < 6; i++) begin
        // jumps by multiples of a full turn divided by 2^k vanish after scaling
        base = 18'(i * 64 + ((i * 5 + 3) % (1 << k)) * (32'h40000 >> k));
        step("R4 psk", 1, base);
        if (i > 0) chk("R4 modulation stripped", 32'(out_freq), 32'((64 << k) >> 2));
      end
    end
  endtask

  task automatic t_gaps();
    cfg_word = mk_cfg(1, 0, 1);
    step("R9 a", 1, 18'd0);
    step("R9 idle", 0, 18'h12345);
    step("R9 b", 1, 18'd400);
    step("R9 idle", 0, 18'h3FFFF);
    step("R9 idle", 0, 18'h00001);
    step("R9 c", 1, 18'd800);
    chk("R9 gaps ignored", 32'(out_freq), 32'd200);
    step("R6 idle after pulse", 0, 18'd0);
    chk("R6 pulse one cycle", 32'(out_valid), 0);
    chk("R6 freq held", 32'(out_freq), 32'd200);
  endtask

  task automatic t_disable();
    cfg_word = mk_cfg(1, 0, 0);
    step("R8 pre", 1, 18'd10);
    step("R8 pre", 1, 18'd20);
    cfg_word = mk_cfg(0, 0, 0);
    for (int i = 0; i < 3; i++) begin
      step("R8 disabled", 1, 18'(30 + i * 10));
      chk("R8 no output while disabled", 32'(out_valid), 0);
    end
    cfg_word = mk_cfg(1, 0, 0);
    step("R8 re-enable first", 1, 18'd1000);
    chk("R8 flushed history", 32'(out_valid), 0);
    step("R8 re-enable second", 1, 18'd1040);
    chk("R8 resumes", 32'(out_freq), 32'd10);
  endtask

  task automatic t_change();
    cfg_word = mk_cfg(1, 0, 0);
    step("R7 pre", 1, 18'd0);
    step("R7 pre", 1, 18'd8);
    cfg_word = mk_cfg(1, 0, 2);
    for (int i = 0; i < 3; i++) begin
      step("R7 refill after change", 1, 18'(16 + i * 8));
      chk("R7 silent after delay change", 32'(out_valid), 0);
    end
    step("R2 D=3 output", 1, 18'd40);
    chk("R2 D=3 slope", 32'(out_freq), 32'd6);
  endtask

  initial begin
    do_reset();
    t_round();
    t_wrap();
    t_delay8();
    t_psk();
    t_gaps();
    t_disable();
    t_change();
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule